// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards the transmit path of a 10 Mb/s Ethernet transmitter against a runaway sender. It watches the internal transmit-active request and counts how many consecutive clock cycles it stays high. If the request stays up longer than a jab limit, the block forces the gated transmit enable low. It keeps the enable low for as long as the request stays asserted. The lockout ends only after the request has been quiet for an unbroken unjab interval. The unjab interval is far longer than the jab limit. A jabber status bit reports the lockout to a management status register.

Both limits are cycle-count parameters. Their defaults assume a 25 MHz timing clock and give 25 ms for jab and 500 ms for unjab. A simulation can override them with small values. At 100 Mb/s and 1000 Mb/s the watchdog is bypassed: the enable follows the request and the status bit reads zero.

The control is a five-state machine:
- `ST_IDLE`: not at 10 Mb/s.
- `ST_ARMED`: 10 Mb/s, request low, no jab.
- `ST_TIMING`: request high, jab counter running.
- `ST_JABBED`: locked out, request high.
- `ST_UNJAB`: locked out, request low, quiet counter running.

The transitions are:
- `ST_IDLE` goes to `ST_ARMED` on the first edge at 10 Mb/s.
- `ST_ARMED` goes to `ST_TIMING` when the request is high.
- `ST_TIMING` goes back to `ST_ARMED` when the request drops.
- `ST_TIMING` goes to `ST_JABBED` on the last allowed high sample.
- `ST_JABBED` goes to `ST_UNJAB` when the request drops.
- `ST_UNJAB` goes back to `ST_JABBED` if the request rises again.
- `ST_UNJAB` goes to `ST_ARMED` after the last quiet sample.
- Every state goes to `ST_IDLE` when the speed is not 10 Mb/s.

Top module: `tx_jabber_guard`

## Requirements
- R1: At 10 Mb/s, suppose the request is sampled high on JAB_CYCLES consecutive rising edges. The first JAB_CYCLES of those edges are counted from `ST_ARMED` or `ST_TIMING`. Then `tx_en_out` is low and `jab_status` is high from the cycle after the last of those edges.
- R2: While locked out, `tx_en_out` stays low and `jab_status` stays high for as long as `tx_req` stays asserted.
- R3: Once locked out, the request must be sampled low on UNJAB_CYCLES consecutive edges. In the cycle after the last of those edges, `jab_status` drops and `tx_en_out` follows `tx_req` again.
- R4: At 10 Mb/s, a burst of fewer than JAB_CYCLES high samples never raises `jab_status`. A single low sample clears the jab count, so bursts separated by gaps never accumulate.
- R5: A request that rises during the quiet period restarts the unjab count from zero. A full UNJAB_CYCLES of fresh low samples is then needed.
- R6: `speed_sel` encodes 2'b00 as 10 Mb/s, 2'b01 as 100 Mb/s and 2'b10 as 1000 Mb/s; 2'b11 is treated like 1000 Mb/s.
- R7: At any speed code other than 2'b00, within the same cycle, `tx_en_out` equals `tx_req` and `jab_status` is 0. Any jab or lockout state is cleared. After a return to 10 Mb/s, the first edge only arms the watchdog and is not counted.
- R8: During and right after reset, `jab_status` is 0. When not locked out at 10 Mb/s, `tx_en_out` equals `tx_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Link speed code (see R6) |
| tx_req | input | 1 | Internal transmit-active request |
| tx_en_out | output | 1 | Gated transmit enable to the driver |
| jab_status | output | 1 | Jabber indication for the status register |

## Verification
The assertions assume that `speed_sel` and `tx_req` are synchronous to `clk` and stable around each rising edge. They also assume that the status bit is only meaningful while the speed code is 10 Mb/s. The bench changes inputs on the falling edge only and samples one time unit later, so every check sees the state from the preceding rising edge. The bench uses short limits of 8 and 12 cycles. It sweeps burst lengths, interrupt points in the quiet period, and every non-10 speed code. The expected enable and status values are derived by counting samples against those limits.

// File: rtl/tx_jabber_pkg.sv
package tx_jabber_pkg;

    typedef enum logic [1:0] {
        SPD_10M   = 2'b00,
        SPD_100M  = 2'b01,
        SPD_1000M = 2'b10,
        SPD_RSVD  = 2'b11
    } speed_code_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_TIMING = 3'd2,
        ST_JABBED = 3'd3,
        ST_UNJAB  = 3'd4
    } jab_state_e;

endpackage

// File: rtl/jab_speed_decode.sv
module jab_speed_decode
    import tx_jabber_pkg::*;
(
    input  logic [1:0] speed_sel,
    output logic       is_10m
);
    always_comb begin
        unique case (speed_sel)
            SPD_10M:   is_10m = 1'b1;
            SPD_100M:  is_10m = 1'b0;
            SPD_1000M: is_10m = 1'b0;
            default:   is_10m = 1'b0;
        endcase
    end
endmodule

// File: rtl/jab_run_counter.sv
module jab_run_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/jab_fsm.sv
module jab_fsm
    import tx_jabber_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_10m,
    input  logic tx_req,
    input  logic jab_last,
    input  logic unj_last,
    output logic gate_open,
    output logic locked,
    output logic jab_inc,
    output logic jab_clr,
    output logic unj_inc,
    output logic unj_clr
);
    jab_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!is_10m) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_ARMED;
                ST_ARMED:  state_d = tx_req ? ST_TIMING : ST_ARMED;
                ST_TIMING: begin
                    if (!tx_req)       state_d = ST_ARMED;
                    else if (jab_last) state_d = ST_JABBED;
                end
                ST_JABBED: state_d = tx_req ? ST_JABBED : ST_UNJAB;
                ST_UNJAB: begin
                    if (tx_req)        state_d = ST_JABBED;
                    else if (unj_last) state_d = ST_ARMED;
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        gate_open = 1'b1;
        locked    = 1'b0;
        jab_inc   = 1'b0;
        jab_clr   = 1'b1;
        unj_inc   = 1'b0;
        unj_clr   = 1'b1;
        if (is_10m) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ARMED: begin
                    jab_inc = tx_req;
                    jab_clr = !tx_req;
                end
                ST_TIMING: begin
                    jab_inc = tx_req && !jab_last;
                    jab_clr = !tx_req || jab_last;
                end
                ST_JABBED: begin
                    gate_open = 1'b0;
                    locked    = 1'b1;
                    unj_inc   = !tx_req;
                    unj_clr   = tx_req;
                end
                ST_UNJAB: begin
                    gate_open = 1'b0;
                    locked    = 1'b1;
                    unj_inc   = !tx_req && !unj_last;
                    unj_clr   = tx_req || unj_last;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
    parameter int JAB_CYCLES   = 625_000,
    parameter int UNJAB_CYCLES = 12_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_sel,
    input  logic       tx_req,
    output logic       tx_en_out,
    output logic       jab_status
);
    logic is_10m;
    logic gate_open, locked;
    logic jab_inc, jab_clr, jab_last;
    logic unj_inc, unj_clr, unj_last;

    jab_speed_decode u_spd (
        .speed_sel (speed_sel),
        .is_10m    (is_10m)
    );

    jab_run_counter #(.LIMIT(JAB_CYCLES)) u_jab_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (jab_clr),
        .inc     (jab_inc),
        .at_last (jab_last)
    );

    jab_run_counter #(.LIMIT(UNJAB_CYCLES)) u_unj_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (unj_clr),
        .inc     (unj_inc),
        .at_last (unj_last)
    );

    jab_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_10m    (is_10m),
        .tx_req    (tx_req),
        .jab_last  (jab_last),
        .unj_last  (unj_last),
        .gate_open (gate_open),
        .locked    (locked),
        .jab_inc   (jab_inc),
        .jab_clr   (jab_clr),
        .unj_inc   (unj_inc),
        .unj_clr   (unj_clr)
    );

    assign tx_en_out  = tx_req && gate_open;
    assign jab_status = locked;
endmodule

// File: rtl/tx_jabber_guard_chk.sv
module tx_jabber_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] speed_sel,
    input logic       tx_req,
    input logic       tx_en_out,
    input logic       jab_status
);
    logic at10;
    assign at10 = (speed_sel == 2'b00);

    AST_BYPASS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        !at10 |-> (tx_en_out == tx_req) && !jab_status); // R7

    AST_LOCK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        jab_status |-> !tx_en_out); // R2

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_status && tx_req && at10) |=> (jab_status || !at10)); // R2

    AST_JAB_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!jab_status && !tx_req) |=> !jab_status); // R1

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(jab_status) && at10) |-> $past(!tx_req)); // R3

    AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !jab_status |-> (tx_en_out == tx_req)); // R8
endmodule

bind tx_jabber_guard tx_jabber_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .speed_sel  (speed_sel),
    .tx_req     (tx_req),
    .tx_en_out  (tx_en_out),
    .jab_status (jab_status)
);

// File: tb/tx_jabber_guard_tb.sv
`timescale 1ns/1ps
module tx_jabber_guard_tb;
    localparam int JAB = 8;
    localparam int UNJ = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed_sel = 2'b00;
    logic       tx_req = 1'b0;
    logic       tx_en_out, jab_status;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    tx_jabber_guard #(.JAB_CYCLES(JAB), .UNJAB_CYCLES(UNJ)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_sel  (speed_sel),
        .tx_req     (tx_req),
        .tx_en_out  (tx_en_out),
        .jab_status (jab_status)
    );

    task automatic check(input string req, input logic exp_en, input logic exp_st);
        n_chk++;
        if (tx_en_out !== exp_en || jab_status !== exp_st) begin
            n_bad++;
            $display("FAIL %s: en=%b st=%b expected en=%b st=%b at %0t",
                     req, tx_en_out, jab_status, exp_en, exp_st, $time);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] s);
        @(negedge clk);
        tx_req = r;
        speed_sel = s;
        #1;
    endtask

    task automatic jab_now();
        for (int i = 1; i <= JAB + 1; i++) step(1'b1, 2'b00);
    endtask

    task automatic release_now();
        for (int j = 1; j <= UNJ + 1; j++) step(1'b0, 2'b00);
    endtask

    initial begin
        #1;
        check("R8 reset", 1'b0, 1'b0);
        tx_req = 1'b1;
        #1;
        check("R8 reset", 1'b1, 1'b0);
        tx_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 2'b00);
        step(1'b0, 2'b00);
        check("R8 after reset", 1'b0, 1'b0);

        // R1 R4 R3: burst-length sweep
        for (int len = 1; len <= JAB + 4; len++) begin
            for (int i = 1; i <= len; i++) begin
                step(1'b1, 2'b00);
                check(len >= JAB ? "R1 burst" : "R4 short burst", i <= JAB, i > JAB);
            end
            for (int j = 1; j <= UNJ + 1; j++) begin
                step(1'b0, 2'b00);
                check("R3 quiet", 1'b0, (len >= JAB) && (j <= UNJ));
            end
            step(1'b1, 2'b00);
            check("R3 reopened", 1'b1, 1'b0);
            step(1'b0, 2'b00);
        end

        // R4: gaps reset the jab count
        for (int g = 1; g <= 3; g++) begin
            for (int rep = 0; rep < 3; rep++) begin
                for (int i = 0; i < JAB - 1; i++) begin
                    step(1'b1, 2'b00);
                    check("R4 gapped", 1'b1, 1'b0);
                end
                for (int k = 0; k < g; k++) begin
                    step(1'b0, 2'b00);
                    check("R4 gap", 1'b0, 1'b0);
                end
            end
        end

        // R5 R2: request returns mid-quiet
        for (int k = 1; k < UNJ; k++) begin
            jab_now();
            for (int j = 0; j < k; j++) begin
                step(1'b0, 2'b00);
                check("R5 quiet", 1'b0, 1'b1);
            end
            for (int h = 0; h < 3; h++) begin
                step(1'b1, 2'b00);
                check("R2 relock", 1'b0, 1'b1);
            end
            for (int j = 1; j <= UNJ + 1; j++) begin
                step(1'b0, 2'b00);
                check("R5 restart", 1'b0, j <= UNJ);
            end
        end

        // R6 R7: speed codes other than 10 Mb/s
        for (int s = 1; s <= 3; s++) begin
            jab_now();
            step(1'b1, 2'(s));
            check("R7 leave jab", 1'b1, 1'b0);
            step(1'b0, 2'(s));
            check("R6 bypass", 1'b0, 1'b0);
            for (int i = 0; i < 3 * JAB; i++) begin
                step(1'b1, 2'(s));
                check("R6 long bypass", 1'b1, 1'b0);
            end
            step(1'b1, 2'b00);
            check("R7 return", 1'b1, 1'b0);
            for (int i = 1; i <= JAB + 1; i++) begin
                step(1'b1, 2'b00);
                check("R7 fresh count", i <= JAB, i > JAB);
            end
            release_now();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule